// File: doc/BRIEF.md
# Two-Phase Multiplexed Bus Sampler

This block samples a bus on which address and data take turns on the same wires. It watches a small group of probe clock lines. Each of two qualifiers, called slave and master, picks an edge condition on each of those lines. In demultiplex mode the block first waits for the slave qualifier and latches the low byte of a 16-bit probe pod. It then waits for the master qualifier and latches the low byte a second time. The two bytes leave the block as one 16-bit word, marked by a single-cycle valid strobe.

With demultiplex mode off, the slave qualifier has no effect. Each master match then captures all sixteen pod lines as one sample. The probe clock lines are registered in the system clock domain, and edges are found by comparing each line with its registered value. A capture takes the pod value present in the cycle where the edge is seen.

Top module: `mux_bus_sampler`

## Requirements
- R1: After a synchronous active-low reset, `smp_vld_o` is 0 and `smp_o` is 0. The sequencer waits for the slave qualifier.
- R2: Qualifier field i sits at bits [2i+1:2i] of `slv_qual_i`/`mst_qual_i`. Its values are 00 ignore, 01 rising edge, 10 falling edge and 11 either edge. A qualifier matches when any probe line shows the edge its field selects. An edge is a change between the previous cycle's value and the current value of `prb_clk_i`.
- R3: In demultiplex mode, while waiting for the slave, a slave match latches `pod_i[7:0]` and the block moves to waiting for the master.
- R4: In demultiplex mode, while waiting for the master, a master match leads, one cycle later, to `smp_o = {pod_i[7:0] at the master match, slave byte}` with `smp_vld_o` = 1. The sequencer then returns to waiting for the slave.
- R5: While waiting for the master, slave matches have no effect on the held slave byte.
- R6: While waiting for the slave, a cycle in which both qualifiers match performs only the slave capture. The master is then awaited on a later match.
- R7: In demultiplex mode, master matches while waiting for the slave produce no sample.
- R8: In demultiplex mode, `pod_i[15:8]` has no effect on any output.
- R9: A cycle in which `demux_en_i` differs from its value in the previous cycle captures nothing and produces no sample. It returns the sequencer to waiting for the slave and discards a slave byte already latched.
- R10: With `demux_en_i` = 0, each master match leads, one cycle later, to `smp_o = pod_i` with `smp_vld_o` = 1. Slave matches have no effect.
- R11: `smp_vld_o` is high only in the cycle after a completing capture. `smp_o` holds its value between samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| demux_en_i | input | 1 | 1 = two-phase demultiplex mode, 0 = single-phase 16-bit capture |
| prb_clk_i | input | NCLK | Probe clock lines |
| slv_qual_i | input | 2*NCLK | Slave qualifier, two bits per probe line |
| mst_qual_i | input | 2*NCLK | Master qualifier, two bits per probe line |
| pod_i | input | 16 | Probe pod data lines |
| smp_o | output | 16 | Captured sample |
| smp_vld_o | output | 1 | One-cycle strobe for a new sample |

## Verification
The assertions check, on every cycle, the sequencer step that follows each qualifier match. They cover the slave-to-master advance, the holding of the slave byte while the master is awaited, the sample contents after a completing match in either mode, the effect of a mode change, and the rule that a qualifier hit needs a detected edge. Only the bench scenarios can show that the per-line field encoding picks the right edges. They also show that the upper pod byte and stray master matches leave the outputs untouched, that the slave-first priority holds on a coincident match, and that long random runs of edges and mode toggles produce exactly the expected stream of samples.

// File: rtl/mux_bus_sampler_pkg.sv
// Package: shared types for the two-phase multiplexed bus sampler.
// Assumes: qualifier fields are two bits per probe clock line.
package mux_bus_sampler_pkg;
    // per-line edge selection encoding
    typedef enum logic [1:0] {
        EDG_OFF  = 2'b00,
        EDG_RISE = 2'b01,
        EDG_FALL = 2'b10,
        EDG_ANY  = 2'b11
    } edge_sel_e;

    // capture sequencer phase
    typedef enum logic {
        PH_WAIT_SLV = 1'b0,
        PH_WAIT_MST = 1'b1
    } cap_phase_e;
endpackage

// File: rtl/prb_edge_det.sv
// Module: prb_edge_det
// Registers the probe clock lines in the system clock domain and reports
// rising and falling transitions per line for the current cycle.
// Assumes: the probe lines are already synchronous to clk.
module prb_edge_det #(
    parameter int NCLK = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCLK-1:0] prb_clk_i,
    output logic [NCLK-1:0] rise_o,
    output logic [NCLK-1:0] fall_o
);
    logic [NCLK-1:0] prb_q;

    // hold last cycle's probe line levels
    always_ff @(posedge clk) begin
        if (!rst_n) prb_q <= '0;
        else        prb_q <= prb_clk_i;
    end

    // transitions between the held and current levels
    always_comb begin
        rise_o = prb_clk_i & ~prb_q;
        fall_o = ~prb_clk_i & prb_q;
    end
endmodule

// File: rtl/qual_match.sv
// Module: qual_match
// Evaluates one clock qualifier: each probe line has a two-bit edge
// selection, and the qualifier hits when any line shows its selected edge.
// Assumes: rise/fall vectors come from prb_edge_det for the same cycle.
module qual_match
    import mux_bus_sampler_pkg::*;
#(
    parameter int NCLK = 4,
    localparam int QW = 2 * NCLK
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [QW-1:0]   qual_i,
    input  logic [NCLK-1:0] rise_i,
    input  logic [NCLK-1:0] fall_i,
    output logic            hit_o
);
    logic [NCLK-1:0] line_hit;

    // per-line match against its edge selection
    for (genvar g = 0; g < NCLK; g++) begin : g_line
        edge_sel_e sel;
        always_comb begin
            sel = edge_sel_e'(qual_i[2*g +: 2]);
            unique case (sel)
                EDG_OFF:  line_hit[g] = 1'b0;
                EDG_RISE: line_hit[g] = rise_i[g];
                EDG_FALL: line_hit[g] = fall_i[g];
                EDG_ANY:  line_hit[g] = rise_i[g] | fall_i[g];
                default:  line_hit[g] = 1'b0;
            endcase
        end
    end

    // any line hitting makes the qualifier hit
    always_comb hit_o = |line_hit;

    // R2
    hit_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> |(rise_i | fall_i));
endmodule

// File: rtl/cap_seq.sv
// Module: cap_seq
// Slave-then-master capture sequencer. In demultiplex mode it latches the
// low pod byte on a slave hit, then the low byte again on a master hit, and
// emits the combined word. Otherwise every master hit captures the full pod.
// Assumes: hit inputs are single-cycle qualifier results for this cycle.
module cap_seq
    import mux_bus_sampler_pkg::*;
#(
    parameter int PW = 16,
    localparam int BW = PW / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          demux_en_i,
    input  logic          slv_hit_i,
    input  logic          mst_hit_i,
    input  logic [PW-1:0] pod_i,
    output logic [PW-1:0] smp_o,
    output logic          smp_vld_o
);
    cap_phase_e    phase;
    logic          en_q;
    logic          mode_chg;
    logic [BW-1:0] slv_byte;

    // a mode toggle aborts whatever is in progress
    always_comb mode_chg = (demux_en_i != en_q);

    // remember the mode to spot toggles
    always_ff @(posedge clk) begin
        en_q <= demux_en_i;
    end

    // phase sequencing and slave byte latch
    always_ff @(posedge clk) begin
        if (!rst_n || mode_chg || !demux_en_i) begin
            phase    <= PH_WAIT_SLV;
            slv_byte <= '0;
        end else if (phase == PH_WAIT_SLV) begin
            if (slv_hit_i) begin
                slv_byte <= pod_i[BW-1:0];
                phase    <= PH_WAIT_MST;
            end
        end else if (mst_hit_i) begin
            phase <= PH_WAIT_SLV;
        end
    end

    // output word and strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_o     <= '0;
            smp_vld_o <= 1'b0;
        end else begin
            smp_vld_o <= 1'b0;
            if (!mode_chg) begin
                if (demux_en_i) begin
                    if (phase == PH_WAIT_MST && mst_hit_i) begin
                        smp_o     <= {pod_i[BW-1:0], slv_byte};
                        smp_vld_o <= 1'b1;
                    end
                end else if (mst_hit_i) begin
                    smp_o     <= pod_i;
                    smp_vld_o <= 1'b1;
                end
            end
        end
    end

    // R1
    rst_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!smp_vld_o && smp_o == '0 && phase == PH_WAIT_SLV));

    // R3
    slv_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (demux_en_i && !mode_chg && phase == PH_WAIT_SLV && slv_hit_i)
        |=> (phase == PH_WAIT_MST && slv_byte == $past(pod_i[BW-1:0])));

    // R5
    slv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (demux_en_i && !mode_chg && phase == PH_WAIT_MST && !mst_hit_i)
        |=> (phase == PH_WAIT_MST && $stable(slv_byte)));

    // R4
    demux_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (demux_en_i && !mode_chg && phase == PH_WAIT_MST && mst_hit_i)
        |=> (smp_vld_o && smp_o == {$past(pod_i[BW-1:0]), $past(slv_byte)}
             && phase == PH_WAIT_SLV));

    // R9
    mode_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> (!smp_vld_o && phase == PH_WAIT_SLV));

    // R10
    plain_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!demux_en_i && !mode_chg && mst_hit_i)
        |=> (smp_vld_o && smp_o == $past(pod_i)));

    // R11
    hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld_o |-> $stable(smp_o) || $past(!rst_n));
endmodule

// File: rtl/mux_bus_sampler.sv
// Module: mux_bus_sampler (top)
// Two-phase multiplexed bus sampler: probe clock edge detection, two
// programmable qualifiers (slave, master) and the capture sequencer.
// Assumes: all inputs synchronous to clk; pod width is even.
module mux_bus_sampler #(
    parameter int NCLK = 4,
    parameter int PW   = 16,
    localparam int QW  = 2 * NCLK
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            demux_en_i,
    input  logic [NCLK-1:0] prb_clk_i,
    input  logic [QW-1:0]   slv_qual_i,
    input  logic [QW-1:0]   mst_qual_i,
    input  logic [PW-1:0]   pod_i,
    output logic [PW-1:0]   smp_o,
    output logic            smp_vld_o
);
    logic [NCLK-1:0] rise;
    logic [NCLK-1:0] fall;
    logic            slv_hit;
    logic            mst_hit;

    prb_edge_det #(.NCLK(NCLK)) edge_i (
        .clk(clk), .rst_n(rst_n), .prb_clk_i(prb_clk_i),
        .rise_o(rise), .fall_o(fall)
    );

    qual_match #(.NCLK(NCLK)) slv_qual_inst (
        .clk(clk), .rst_n(rst_n), .qual_i(slv_qual_i),
        .rise_i(rise), .fall_i(fall), .hit_o(slv_hit)
    );

    qual_match #(.NCLK(NCLK)) mst_qual_inst (
        .clk(clk), .rst_n(rst_n), .qual_i(mst_qual_i),
        .rise_i(rise), .fall_i(fall), .hit_o(mst_hit)
    );

    cap_seq #(.PW(PW)) seq_i (
        .clk(clk), .rst_n(rst_n), .demux_en_i(demux_en_i),
        .slv_hit_i(slv_hit), .mst_hit_i(mst_hit), .pod_i(pod_i),
        .smp_o(smp_o), .smp_vld_o(smp_vld_o)
    );
endmodule

// File: tb/mux_bus_sampler_tb_top.sv
// Bench for mux_bus_sampler: directed corner cases plus seeded random
// stimulus, checked every cycle against a reference model kept in the bench.
`timescale 1ns/1ps
module mux_bus_sampler_tb_top;
    localparam int NCLK = 4;
    localparam int PW   = 16;
    localparam int QW   = 2 * NCLK;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            demux_en;
    logic [NCLK-1:0] prb;
    logic [QW-1:0]   sq, mq;
    logic [PW-1:0]   pod;
    logic [PW-1:0]   smp;
    logic            vld;

    int n_chk = 0;
    int n_bad = 0;

    // reference model state
    logic [NCLK-1:0] m_prev;
    logic            m_wait_mst;
    logic            m_enq;
    logic [7:0]      m_slv;
    logic [PW-1:0]   m_smp;
    logic            m_vld;

    always #4 clk = ~clk;

    mux_bus_sampler #(.NCLK(NCLK), .PW(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .demux_en_i(demux_en), .prb_clk_i(prb),
        .slv_qual_i(sq), .mst_qual_i(mq), .pod_i(pod),
        .smp_o(smp), .smp_vld_o(vld)
    );

    // qualifier hit per the field encoding (R2)
    function automatic logic qhit(logic [QW-1:0] q, logic [NCLK-1:0] cur,
                                  logic [NCLK-1:0] prv);
        logic h = 1'b0;
        for (int i = 0; i < NCLK; i++) begin
            if (q[2*i] && cur[i] && !prv[i]) h = 1'b1;
            if (q[2*i+1] && !cur[i] && prv[i]) h = 1'b1;
        end
        return h;
    endfunction

    // advance the model by one clock edge using current inputs
    task automatic model_step();
        logic sh, mh, chg;
        sh  = qhit(sq, prb, m_prev);
        mh  = qhit(mq, prb, m_prev);
        chg = (demux_en != m_enq);
        m_enq = demux_en;
        if (!rst_n) begin
            m_prev = '0; m_wait_mst = 0; m_slv = '0; m_smp = '0; m_vld = 0;
            return;
        end
        m_prev = prb;
        m_vld  = 0;
        if (chg) begin
            m_wait_mst = 0; m_slv = '0;
        end else if (demux_en) begin
            if (!m_wait_mst) begin
                if (sh) begin m_slv = pod[7:0]; m_wait_mst = 1; end
            end else if (mh) begin
                m_smp = {pod[7:0], m_slv}; m_vld = 1; m_wait_mst = 0;
            end
        end else begin
            m_wait_mst = 0; m_slv = '0;
            if (mh) begin m_smp = pod; m_vld = 1; end
        end
    endtask

    task automatic check(string tag);
        n_chk++;
        if (vld !== m_vld || smp !== m_smp) begin
            n_bad++;
            $display("FAIL %s: vld=%0b smp=%h expected vld=%0b smp=%h",
                     tag, vld, smp, m_vld, m_smp);
        end
    endtask

    // one cycle: drive at negedge, model, compare at the next negedge
    task automatic cyc(logic [NCLK-1:0] p, logic [PW-1:0] d, string tag);
        prb = p; pod = d;
        model_step();
        @(posedge clk);
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        #(8ns * 150000);
        n_bad++; n_chk++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        rst_n = 0; demux_en = 1; prb = '0; pod = '0;
        m_enq = 1;
        // slave: rise on line 0; master: fall on line 1
        sq = 8'b00_00_00_01; mq = 8'b00_00_10_00;
        @(negedge clk);
        for (int i = 0; i < 3; i++) cyc('0, 16'hFFFF, "R1");
        rst_n = 1;
        cyc('0, 16'h0000, "R1");

        // R3/R4/R8: slave rise l0 then master fall l1, upper byte noise
        cyc(4'b0010, 16'hAA00, "R3");
        cyc(4'b0011, 16'h5512, "R3");
        cyc(4'b0001, 16'h66_34, "R8");
        cyc(4'b0001, 16'h0000, "R4");
        // R6: both hit same cycle; l0 rise (slave) and l1 fall (master)
        cyc(4'b0010, 16'h0000, "R6");
        cyc(4'b0001, 16'h0077, "R6");
        cyc(4'b0000, 16'h0000, "R6");
        cyc(4'b0010, 16'h0000, "R6");
        cyc(4'b0000, 16'h0099, "R6");
        // R7: master fall while waiting for slave
        cyc(4'b0010, 16'h0000, "R7");
        cyc(4'b0000, 16'h00EE, "R7");
        // R5: slave, extra slave hits, then master
        cyc(4'b0011, 16'h0011, "R5");
        cyc(4'b0010, 16'h0000, "R5");
        cyc(4'b0011, 16'h0022, "R5");
        cyc(4'b0001, 16'h0033, "R5");
        // R9: slave captured, toggle mode, master must not complete
        cyc(4'b0000, 16'h0000, "R9");
        cyc(4'b0011, 16'h0044, "R9");
        demux_en = 0;
        cyc(4'b0001, 16'h0055, "R9");
        demux_en = 1;
        cyc(4'b0011, 16'h0000, "R9");
        cyc(4'b0001, 16'h0066, "R9");
        // R10: single-phase mode, slave hits ignored
        demux_en = 0;
        cyc(4'b0000, 16'h0000, "R10");
        cyc(4'b0011, 16'h1234, "R10");
        cyc(4'b0001, 16'hBEEF, "R10");
        cyc(4'b0000, 16'h0000, "R10");
        // R2: either-edge and ignored lines
        demux_en = 1;
        sq = 8'b11_00_00_00; mq = 8'b00_11_00_00;
        cyc(4'b0000, 16'h0000, "R2");
        cyc(4'b1000, 16'h00A1, "R2");
        cyc(4'b1001, 16'h00B2, "R2");
        cyc(4'b0101, 16'h00C3, "R2");
        cyc(4'b0001, 16'h00D4, "R2");

        // R11 and R2: random stream
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 99) < 3) begin
                sq = QW'($urandom); mq = QW'($urandom);
            end
            if ($urandom_range(0, 199) == 0) demux_en = ~demux_en;
            cyc(NCLK'($urandom), PW'($urandom), "R11");
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule